// File: doc/BRIEF.md
# DMA Address and Count Engine with Buffer Chaining

This block is the per-channel address and count engine of a DMA channel. It holds the source address, the destination address and the number of bytes still to move. For every beat it gives the width to use, so the bus side knows how large a transfer to issue. When the bus side reports a finished read beat, the engine steps the source address and lowers the count. When it reports a finished write beat, the engine steps the destination address. The source beat shrinks near the end of a buffer so that a read never asks for more bytes than remain.

When the count reaches zero the engine raises a one-cycle count-to-zero strobe. If chaining is armed, it loads source, destination and count from shadow registers in the same cycle, disarms itself and raises a reload strobe, and the channel carries on with the next buffer. If chaining is not armed, the channel goes inactive. Software loads the working registers and the shadow registers through a simple write port. These writes take effect only while the channel is idle. The bus protocol and the FIFO data live outside this block.

Top module: `dma_addr_engine`

## Requirements
- R1: Width codes are 0 = byte (1 byte), 1 = halfword (2 bytes), 2 = word (4 bytes), and code 3 is treated as word. `srcBeatSize` is the smaller of the configured source width and the largest power of two not above the remaining count. `dstBeatSize` is the configured destination width.
- R2: A read beat accepted while active with a nonzero count lowers the count by the source beat's byte count.
- R3: On an accepted read beat with source increment in effect, the source address grows by the source beat's byte count. Otherwise it holds its value.
- R4: On a write beat while active with destination increment in effect, the destination address grows by the destination beat's byte count. Otherwise it holds its value.
- R5: Direction class 1 (receive from a peripheral) forces source increment off. Class 2 (transmit to a peripheral) forces destination increment off. Class 0 (memory to memory) leaves both as configured.
- R6: `ctzPulse` is high for exactly the one cycle after each read beat that takes the count to zero, and is low at all other times.
- R7: When the count reaches zero with reload disarmed, `active` falls in the same cycle that `ctzPulse` rises.
- R8: When the count reaches zero with reload armed, the engine does all of the following in the cycle that `ctzPulse` rises: it loads the source and destination from their 31-bit shadows (address bit 31 becomes 0), loads the count from its 24-bit shadow, pulses `reloadPulse`, clears `reloadEn`, and keeps `active` high.
- R9: Writes with `regWrSel` 0 (source), 1 (destination), 2 (count), 3 (source shadow), 4 (destination shadow) or 5 (count shadow in bits 23:0, reload arm in bit 31) are ignored while `active` is high.
- R10: A write with `regWrSel` 6 and data bit 0 set starts the channel only if it is idle and the count is nonzero. Data bit 1 of a `regWrSel` 6 write sets or clears `reloadEn` at any time. Beat strobes have no effect while the channel is idle.
- R11: After reset, addresses, count and shadows are 0, and `active`, `reloadEn`, `ctzPulse` and `reloadPulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgSrcWidth | input | 2 | Configured source width code |
| cfgDstWidth | input | 2 | Configured destination width code |
| cfgSrcInc | input | 1 | Source increment enable |
| cfgDstInc | input | 1 | Destination increment enable |
| cfgDirClass | input | 2 | 0 memory to memory, 1 receive from peripheral, 2 transmit to peripheral |
| regWrEn | input | 1 | Register write strobe |
| regWrSel | input | 3 | Register select |
| regWrData | input | 32 | Register write data |
| rdBeatDone | input | 1 | A read beat into the FIFO has completed |
| wrBeatDone | input | 1 | A write beat out of the FIFO has completed |
| srcAddr | output | 32 | Current source address |
| dstAddr | output | 32 | Current destination address |
| count | output | 24 | Remaining byte count |
| srcBeatSize | output | 2 | Width code for the next read beat |
| dstBeatSize | output | 2 | Width code for the next write beat |
| ctzPulse | output | 1 | Count-to-zero strobe |
| reloadPulse | output | 1 | Chained reload strobe |
| active | output | 1 | Channel active status |
| reloadEn | output | 1 | Reload armed |

## Verification
The bench sweeps every source width, destination width, increment pairing and direction class over short counts of 1 to 9 bytes. It predicts the shrinking beat width, the count and both addresses beat by beat. A design that sized the tail beat from the configured width would take the count past zero and never raise the end strobe. A design that ignored the direction class would move a peripheral-side address that must stay fixed. A chained run checks that the shadows, which are 31 bits wide, land with address bit 31 clear and that the reload arm clears itself, so that the second buffer ends the channel instead of looping forever. The run also checks that a shadow write made while the channel is active is dropped: otherwise a later reload would pick up the wrong count. Further checks cover beats that arrive while the channel is idle and a start with a zero count.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  localparam logic [1:0] WIDTH_BYTE = 2'd0;
  localparam logic [1:0] WIDTH_HALF = 2'd1;
  localparam logic [1:0] WIDTH_WORD = 2'd2;

  localparam logic [1:0] DIR_MEM = 2'd0;
  localparam logic [1:0] DIR_RX  = 2'd1;
  localparam logic [1:0] DIR_TX  = 2'd2;

  localparam logic [2:0] SEL_SRC     = 3'd0;
  localparam logic [2:0] SEL_DST     = 3'd1;
  localparam logic [2:0] SEL_CNT     = 3'd2;
  localparam logic [2:0] SEL_SRC_RLD = 3'd3;
  localparam logic [2:0] SEL_DST_RLD = 3'd4;
  localparam logic [2:0] SEL_CNT_RLD = 3'd5;
  localparam logic [2:0] SEL_CTRL    = 3'd6;

  typedef struct packed {
    logic srcAdv;
    logic dstAdv;
    logic cntDec;
    logic reload;
  } engStrobeT;
endpackage

// File: rtl/dma_eng_datapath.sv
module dma_eng_datapath
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24,
  parameter int RLD_W  = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  engStrobeT         stb,
  input  logic              wrOk,
  input  logic [2:0]        wrSel,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [1:0]        cfgSrcWidth,
  input  logic [1:0]        cfgDstWidth,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [CNT_W-1:0]  count,
  output logic [1:0]        srcBeat,
  output logic [1:0]        dstBeat,
  output logic              lastBeat,
  output logic              countZero
);
  localparam int PAD_W = ADDR_W - RLD_W;

  logic [RLD_W-1:0]  srcRld, dstRld;
  logic [CNT_W-1:0]  cntRld;
  logic [1:0]        srcCfgW, fitW;
  logic [CNT_W-1:0]  srcBytes;
  logic [ADDR_W-1:0] srcStep, dstStep;

  always_comb begin
    srcCfgW = (cfgSrcWidth > WIDTH_WORD) ? WIDTH_WORD : cfgSrcWidth;
    dstBeat = (cfgDstWidth > WIDTH_WORD) ? WIDTH_WORD : cfgDstWidth;
    if (count >= CNT_W'(4))      fitW = WIDTH_WORD;
    else if (count >= CNT_W'(2)) fitW = WIDTH_HALF;
    else                         fitW = WIDTH_BYTE;
    srcBeat   = (srcCfgW < fitW) ? srcCfgW : fitW;
    srcBytes  = CNT_W'(1) << srcBeat;
    srcStep   = ADDR_W'(1) << srcBeat;
    dstStep   = ADDR_W'(1) << dstBeat;
    countZero = (count == '0);
    lastBeat  = (count == srcBytes);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAddr <= '0;
      dstAddr <= '0;
      count   <= '0;
      srcRld  <= '0;
      dstRld  <= '0;
      cntRld  <= '0;
    end else begin
      if (stb.reload) begin
        srcAddr <= {{PAD_W{1'b0}}, srcRld};
        dstAddr <= {{PAD_W{1'b0}}, dstRld};
        count   <= cntRld;
      end else begin
        if (stb.srcAdv) srcAddr <= srcAddr + srcStep;
        if (stb.dstAdv) dstAddr <= dstAddr + dstStep;
        if (stb.cntDec) count   <= count - srcBytes;
      end
      if (wrOk) begin
        case (wrSel)
          SEL_SRC:     srcAddr <= wrData;
          SEL_DST:     dstAddr <= wrData;
          SEL_CNT:     count   <= wrData[CNT_W-1:0];
          SEL_SRC_RLD: srcRld  <= wrData[RLD_W-1:0];
          SEL_DST_RLD: dstRld  <= wrData[RLD_W-1:0];
          SEL_CNT_RLD: cntRld  <= wrData[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_eng_ctrl.sv
module dma_eng_ctrl
  import dma_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [2:0] regWrSel,
  input  logic       dataStart,
  input  logic       dataArm,
  input  logic       dataRldArm,
  input  logic       rdBeatDone,
  input  logic       wrBeatDone,
  input  logic       srcIncEff,
  input  logic       dstIncEff,
  input  logic       lastBeat,
  input  logic       countZero,
  output engStrobeT  stb,
  output logic       wrOk,
  output logic       active,
  output logic       reloadEn,
  output logic       ctzPulse,
  output logic       reloadPulse
);
  logic rdOk, wrBeatOk, finalBeat;

  always_comb begin
    rdOk       = active && rdBeatDone && !countZero;
    wrBeatOk   = active && wrBeatDone;
    finalBeat  = rdOk && lastBeat;
    wrOk       = regWrEn && !active;
    stb.srcAdv = rdOk && srcIncEff;
    stb.dstAdv = wrBeatOk && dstIncEff;
    stb.cntDec = rdOk;
    stb.reload = finalBeat && reloadEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active      <= 1'b0;
      reloadEn    <= 1'b0;
      ctzPulse    <= 1'b0;
      reloadPulse <= 1'b0;
    end else begin
      ctzPulse    <= finalBeat;
      reloadPulse <= stb.reload;
      if (finalBeat && !reloadEn)
        active <= 1'b0;
      else if (wrOk && regWrSel == SEL_CTRL && dataStart && !countZero)
        active <= 1'b1;
      if (stb.reload)
        reloadEn <= 1'b0;
      else if (regWrEn && regWrSel == SEL_CTRL)
        reloadEn <= dataArm;
      else if (wrOk && regWrSel == SEL_CNT_RLD)
        reloadEn <= dataRldArm;
    end
  end
endmodule

// File: rtl/dma_addr_engine.sv
module dma_addr_engine
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24,
  parameter int RLD_W  = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgSrcWidth,
  input  logic [1:0]        cfgDstWidth,
  input  logic              cfgSrcInc,
  input  logic              cfgDstInc,
  input  logic [1:0]        cfgDirClass,
  input  logic              regWrEn,
  input  logic [2:0]        regWrSel,
  input  logic [ADDR_W-1:0] regWrData,
  input  logic              rdBeatDone,
  input  logic              wrBeatDone,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [CNT_W-1:0]  count,
  output logic [1:0]        srcBeatSize,
  output logic [1:0]        dstBeatSize,
  output logic              ctzPulse,
  output logic              reloadPulse,
  output logic              active,
  output logic              reloadEn
);
  engStrobeT stb;
  logic wrOk, lastBeat, countZero, srcIncEff, dstIncEff;

  assign srcIncEff = cfgSrcInc && (cfgDirClass != DIR_RX);
  assign dstIncEff = cfgDstInc && (cfgDirClass != DIR_TX);

  dma_eng_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .dataStart(regWrData[0]), .dataArm(regWrData[1]),
    .dataRldArm(regWrData[ADDR_W-1]),
    .rdBeatDone(rdBeatDone), .wrBeatDone(wrBeatDone),
    .srcIncEff(srcIncEff), .dstIncEff(dstIncEff),
    .lastBeat(lastBeat), .countZero(countZero),
    .stb(stb), .wrOk(wrOk), .active(active), .reloadEn(reloadEn),
    .ctzPulse(ctzPulse), .reloadPulse(reloadPulse)
  );

  dma_eng_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RLD_W(RLD_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrOk(wrOk), .wrSel(regWrSel),
    .wrData(regWrData), .cfgSrcWidth(cfgSrcWidth), .cfgDstWidth(cfgDstWidth),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .count(count),
    .srcBeat(srcBeatSize), .dstBeat(dstBeatSize),
    .lastBeat(lastBeat), .countZero(countZero)
  );
endmodule

// File: rtl/dma_addr_engine_chk.sv
module dma_addr_engine_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             active,
  input logic             reloadEn,
  input logic [CNT_W-1:0] count,
  input logic [1:0]       srcBeatSize,
  input logic             rdBeatDone,
  input logic             regWrEn,
  input logic             ctzPulse,
  input logic             reloadPulse
);
  logic [CNT_W-1:0] beatBytes;
  assign beatBytes = CNT_W'(1) << srcBeatSize;

  a_r1_beat_fits: assert property (@(posedge clk) disable iff (!rstN)
    (count != '0) |-> (srcBeatSize <= 2'd2 && beatBytes <= count));

  a_r2_count_dec: assert property (@(posedge clk) disable iff (!rstN)
    (active && rdBeatDone && count > beatBytes) |=> (count == $past(count) - $past(beatBytes)));

  a_r7_end_drops_active: assert property (@(posedge clk) disable iff (!rstN)
    (ctzPulse && !reloadPulse) |-> !active);

  a_r8_reload_with_ctz: assert property (@(posedge clk) disable iff (!rstN)
    reloadPulse |-> (ctzPulse && active && !reloadEn));

  a_r9_idle_count_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !regWrEn) |=> $stable(count));

  a_r10_start_needs_count: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> (count != '0));
endmodule

bind dma_addr_engine dma_addr_engine_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .active(active), .reloadEn(reloadEn),
  .count(count), .srcBeatSize(srcBeatSize), .rdBeatDone(rdBeatDone),
  .regWrEn(regWrEn), .ctzPulse(ctzPulse), .reloadPulse(reloadPulse)
);

// File: tb/dma_addr_engine_tb.sv
module dma_addr_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  cfgSrcWidth, cfgDstWidth, cfgDirClass;
  logic        cfgSrcInc, cfgDstInc;
  logic        regWrEn;
  logic [2:0]  regWrSel;
  logic [31:0] regWrData;
  logic        rdBeatDone, wrBeatDone;
  logic [31:0] srcAddr, dstAddr;
  logic [23:0] count;
  logic [1:0]  srcBeatSize, dstBeatSize;
  logic        ctzPulse, reloadPulse, active, reloadEn;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_addr_engine u_dut (
    .clk(clk), .rstN(rstN), .cfgSrcWidth(cfgSrcWidth), .cfgDstWidth(cfgDstWidth),
    .cfgSrcInc(cfgSrcInc), .cfgDstInc(cfgDstInc), .cfgDirClass(cfgDirClass),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .rdBeatDone(rdBeatDone), .wrBeatDone(wrBeatDone),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .count(count),
    .srcBeatSize(srcBeatSize), .dstBeatSize(dstBeatSize),
    .ctzPulse(ctzPulse), .reloadPulse(reloadPulse), .active(active), .reloadEn(reloadEn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] sel, input logic [31:0] data);
    regWrEn = 1'b1; regWrSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic beat(input logic rd, input logic wr);
    rdBeatDone = rd; wrBeatDone = wr;
    @(negedge clk);
    rdBeatDone = 1'b0; wrBeatDone = 1'b0;
  endtask

  function automatic int fitW(input int c);
    return (c >= 4) ? 2 : (c >= 2) ? 1 : 0;
  endfunction

  task automatic sweepRun(input int dir, input int sw, input int dw,
                          input int si, input int di, input int cnt);
    logic [31:0] es, ed;
    int ec, w;
    string srcTag, dstTag;
    cfgDirClass = 2'(dir); cfgSrcWidth = 2'(sw); cfgDstWidth = 2'(dw);
    cfgSrcInc = 1'(si); cfgDstInc = 1'(di);
    es = 32'h1000_0003; ed = 32'h8000_0010; ec = cnt;
    regWrite(3'd0, es);
    regWrite(3'd1, ed);
    regWrite(3'd2, 32'(cnt));
    regWrite(3'd6, 32'h1);
    chk("R10 start active", 32'(active), 32'd1);
    srcTag = (dir == 1 && si == 1) ? "R5 src forced hold" : "R3 src addr";
    dstTag = (dir == 2 && di == 1) ? "R5 dst forced hold" : "R4 dst addr";
    while (ec > 0) begin
      w = (sw < fitW(ec)) ? sw : fitW(ec);
      chk("R1 src beat width", 32'(srcBeatSize), 32'(w));
      chk("R1 dst beat width", 32'(dstBeatSize), 32'(dw));
      beat(1'b1, 1'b1);
      ec -= (1 << w);
      if (si == 1 && dir != 1) es += 32'(1 << w);
      if (di == 1 && dir != 2) ed += 32'(1 << dw);
      chk("R2 count", 32'(count), 32'(ec));
      chk(srcTag, srcAddr, es);
      chk(dstTag, dstAddr, ed);
      chk("R6 ctz strobe", 32'(ctzPulse), (ec == 0) ? 32'd1 : 32'd0);
      if (ec == 0) chk("R7 end drops active", 32'(active), 32'd0);
    end
    @(negedge clk);
    chk("R6 ctz one cycle", 32'(ctzPulse), 32'd0);
  endtask

  initial begin
    rstN = 1'b0; regWrEn = 0; regWrSel = 0; regWrData = 0;
    rdBeatDone = 0; wrBeatDone = 0;
    cfgSrcWidth = 0; cfgDstWidth = 0; cfgDirClass = 0; cfgSrcInc = 0; cfgDstInc = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 reset active", 32'(active), 32'd0);
    chk("R11 reset count", 32'(count), 32'd0);
    chk("R11 reset src", srcAddr, 32'd0);
    chk("R11 reset dst", dstAddr, 32'd0);
    chk("R11 reset ctz", 32'(ctzPulse), 32'd0);
    chk("R11 reset reload", 32'(reloadPulse), 32'd0);
    chk("R11 reset rlden", 32'(reloadEn), 32'd0);

    regWrite(3'd6, 32'h1);
    chk("R10 zero count start refused", 32'(active), 32'd0);

    for (int dir = 0; dir < 3; dir++)
      for (int sw = 0; sw < 3; sw++)
        for (int dw = 0; dw < 3; dw++)
          for (int inc = 0; inc < 4; inc++)
            for (int c = 1; c <= 9; c += 2)
              sweepRun(dir, sw, dw, inc & 1, inc >> 1, c);

    cfgDirClass = 0; cfgSrcWidth = 2'd3; cfgDstWidth = 2'd3; cfgSrcInc = 1; cfgDstInc = 1;
    chk("R1 code 3 treated as word", 32'(dstBeatSize), 32'd2);
    regWrite(3'd2, 32'd5);
    beat(1'b1, 1'b1);
    chk("R10 idle beat count", 32'(count), 32'd5);
    chk("R10 idle beat src", srcAddr, 32'h1000_0003 + 32'd9);

    regWrite(3'd0, 32'h100);
    regWrite(3'd1, 32'h200);
    regWrite(3'd2, 32'd8);
    regWrite(3'd3, 32'hFFFF_FFF0);
    regWrite(3'd4, 32'h300);
    regWrite(3'd5, 32'h8000_0006);
    chk("R8 arm via shadow write", 32'(reloadEn), 32'd1);
    regWrite(3'd6, 32'h3);
    beat(1'b1, 1'b1);
    chk("R2 chain first beat", 32'(count), 32'd4);
    beat(1'b1, 1'b1);
    chk("R6 ctz on chain", 32'(ctzPulse), 32'd1);
    chk("R8 reload strobe", 32'(reloadPulse), 32'd1);
    chk("R8 stays active", 32'(active), 32'd1);
    chk("R8 src from shadow", srcAddr, 32'h7FFF_FFF0);
    chk("R8 dst from shadow", dstAddr, 32'h300);
    chk("R8 count from shadow", 32'(count), 32'd6);
    chk("R8 arm cleared", 32'(reloadEn), 32'd0);

    regWrite(3'd0, 32'hDEAD_0000);
    chk("R9 src write ignored", srcAddr, 32'h7FFF_FFF0);
    regWrite(3'd5, 32'h0000_0003);
    regWrite(3'd6, 32'h2);
    chk("R10 arm while active", 32'(reloadEn), 32'd1);
    chk("R1 chain beat word", 32'(srcBeatSize), 32'd2);
    beat(1'b1, 1'b0);
    chk("R1 chain beat shrinks", 32'(srcBeatSize), 32'd1);
    beat(1'b1, 1'b0);
    chk("R8 second reload", 32'(reloadPulse), 32'd1);
    chk("R9 shadow write ignored", 32'(count), 32'd6);
    beat(1'b1, 1'b0);
    beat(1'b1, 1'b0);
    chk("R6 final ctz", 32'(ctzPulse), 32'd1);
    chk("R7 no reload strobe", 32'(reloadPulse), 32'd0);
    chk("R7 channel ended", 32'(active), 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule